// File: doc/BRIEF.md
# UART Receive Buffer with Trigger Level

This block sits between a UART deserializer and the byte-wide host register interface. Each received character arrives as one push carrying eight data bits and three error flags: parity, framing and break. The block holds up to sixteen such entries in arrival order. The host reads the oldest entry with a pop. The entry at the head is always visible on the output pins, so the host sees the character and its flags before it pops.

Software controls the buffer through a configuration write, which carries three things: a 2-bit trigger-level code, a clear command and a mode bit. In holding mode (mode bit 0) the block keeps a single character, like a plain receive holding register. In buffered mode (mode bit 1) it keeps up to the full depth.

The block has several outputs:
- A data-ready indication that is high whenever the buffer is not empty.
- A trigger indication that is high when occupancy reaches the selected level.
- A sticky overrun flag that records a character lost for lack of space. A line-status read clears it.
- A summary error flag that reports whether any stored entry carries an error.

Top module: `rx_fifo_trig`

## Requirements
- R1: After reset the occupancy is 0, `data_ready`, `trig_hit`, `overrun` and `fifo_err` are 0, holding mode is selected and the trigger code is 00.
- R2: Entries leave in the order they arrived. While the buffer is not empty, `head_data`, `head_par`, `head_frm` and `head_brk` show the oldest stored entry exactly as it was pushed. An accepted pop removes that entry at the next clock edge.
- R3: `trig_hit` is 1 exactly when occupancy is at least the selected level. The trigger code maps as follows: 00 is 1 character, 01 is 4, 10 is 8 and 11 is 14.
- R4: `data_ready` is 1 exactly when occupancy is non-zero. A pop while the buffer is empty changes nothing.
- R5: In holding mode the capacity is one entry. A second push without a pop is discarded, and the stored character stays at the head.
- R6: In buffered mode the capacity is 16 entries.
  - A push while the buffer is full and no pop is accepted discards the new character.
  - That discard sets `overrun` from the next edge on. `overrun` stays set until a `lsr_rd` pulse clears it at the following edge.
  - If a discard and `lsr_rd` happen in the same cycle, the flag ends up set.
  - A push to a full buffer in the same cycle as a pop is accepted.
- R7: A configuration write with `cfg_clr_rx` = 1 empties the buffer at the next edge. A push in that same cycle is discarded without setting `overrun`. The clear is a command and leaves no stored state behind.
- R8: A configuration write whose `cfg_fifo_en` differs from the current mode switches mode and also empties the buffer. A write that keeps the same mode and has `cfg_clr_rx` = 0 leaves the contents untouched.
- R9: `fifo_err` is 1 exactly when buffered mode is on and at least one stored entry has a parity, framing or break flag set. It is 0 in holding mode.
- R10: `level` always equals the number of stored entries, and it never exceeds the depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | Deserializer delivers a character this cycle |
| push_data | input | 8 | Received character |
| push_par | input | 1 | Parity error flag of the character |
| push_frm | input | 1 | Framing error flag of the character |
| push_brk | input | 1 | Break flag of the character |
| pop | input | 1 | Host reads the head entry |
| lsr_rd | input | 1 | Host reads line status; clears overrun |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_fifo_en | input | 1 | Mode bit: 1 buffered, 0 holding |
| cfg_clr_rx | input | 1 | Clear command (not stored) |
| cfg_trig_sel | input | 2 | Trigger-level code |
| head_data | output | 8 | Data of the oldest entry |
| head_par | output | 1 | Parity flag of the oldest entry |
| head_frm | output | 1 | Framing flag of the oldest entry |
| head_brk | output | 1 | Break flag of the oldest entry |
| level | output | 5 | Current occupancy |
| data_ready | output | 1 | Buffer not empty |
| trig_hit | output | 1 | Occupancy at or above trigger level |
| overrun | output | 1 | Sticky lost-character flag |
| fifo_err | output | 1 | Some stored entry carries an error (buffered mode) |

## Verification
The bench builds the block with its default depth of 16. With that depth all four trigger levels, including 14, lie below the capacity, so each threshold crossing can be checked as well as the full-buffer overrun at entry 17. Directed sequences fill the buffer to capacity in both modes and exercise clears and mode toggles against pushes in the same cycle. A long seeded random run then mixes pushes with error flags, pops, status reads and occasional reconfiguration. During that run the error summary is watched as erroneous entries are stored and drained.

// File: rtl/rxf_pkg.sv
// Shared types and helpers for the receive buffer.
// Assumes an 8-bit character and three per-character error flags.
package rxf_pkg;

    localparam int unsigned CHAR_W = 8;

    // One stored character together with its error flags.
    typedef struct packed {
        logic              brk;
        logic              frm;
        logic              par;
        logic [CHAR_W-1:0] data;
    } rx_entry_t;

    // Trigger threshold for a 2-bit code, limited to the buffer depth.
    function automatic int unsigned trig_level(input logic [1:0] sel,
                                               input int unsigned depth);
        int unsigned lv;
        case (sel)
            2'b00:   lv = 1;
            2'b01:   lv = 4;
            2'b10:   lv = 8;
            default: lv = 14;
        endcase
        return (lv > depth) ? depth : lv;
    endfunction

endpackage

// File: rtl/rxf_store.sv
// Circular storage for received entries.
// Assumes the caller only asserts wr_en when space exists and rd_en when
// an entry exists; flush resets both pointers.
module rxf_store
    import rxf_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      flush,
    input  logic      wr_en,
    input  logic      rd_en,
    input  rx_entry_t wr_entry,
    output rx_entry_t head
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    rx_entry_t        slot [DEPTH];

    // Advance a pointer with wrap at the last slot.
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    // Pointer update: flush returns both to slot 0.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_en) wr_ptr <= bump(wr_ptr);
            if (rd_en) rd_ptr <= bump(rd_ptr);
        end
    end

    // One register per slot, written when the write pointer selects it.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot[g] <= '0;
            end else if (wr_en && !flush && wr_ptr == PTR_W'(g)) begin
                slot[g] <= wr_entry;
            end
        end
    end

    assign head = slot[rd_ptr];

endmodule

// File: rtl/rxf_occ.sv
// Occupancy and admission control.
// Decides which pushes and pops take effect and counts entries and
// erroneous entries. Capacity is the full depth in buffered mode, else one.
module rxf_occ #(
    parameter int unsigned DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         fifo_en,
    input  logic                         push_req,
    input  logic                         push_bad,
    input  logic                         pop_req,
    input  logic                         head_bad,
    output logic                         push_ok,
    output logic                         pop_ok,
    output logic                         drop,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         any_bad
);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CAP = CNT_W'(DEPTH);

    logic [CNT_W-1:0] cap;
    logic             full;
    logic [CNT_W-1:0] bad_cnt;

    // Admission: flush wins; a full buffer accepts only alongside a pop.
    always_comb begin
        cap     = fifo_en ? FULL_CAP : CNT_W'(1);
        full    = (count >= cap);
        pop_ok  = pop_req && (count != '0) && !flush;
        push_ok = push_req && !flush && (!full || pop_ok);
        drop    = push_req && !flush && !push_ok;
    end

    // Entry counter.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            count <= '0;
        end else begin
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Counter of stored entries that carry any error flag.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            bad_cnt <= '0;
        end else begin
            case ({push_ok && push_bad, pop_ok && head_bad})
                2'b10:   bad_cnt <= bad_cnt + 1'b1;
                2'b01:   bad_cnt <= bad_cnt - 1'b1;
                default: bad_cnt <= bad_cnt;
            endcase
        end
    end

    assign any_bad = (bad_cnt != '0);

endmodule

// File: rtl/rxf_cfg.sv
// Configuration and sticky status.
// Holds the mode bit and trigger code, turns clear commands and mode
// changes into a one-cycle flush, and keeps the overrun flag.
module rxf_cfg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic       cfg_fifo_en,
    input  logic       cfg_clr_rx,
    input  logic [1:0] cfg_trig_sel,
    input  logic       lsr_rd,
    input  logic       drop,
    output logic       fifo_en_q,
    output logic [1:0] trig_sel_q,
    output logic       flush,
    output logic       overrun_q
);
    // Flush on an explicit clear or on any change of mode.
    assign flush = cfg_wr && (cfg_clr_rx || (cfg_fifo_en != fifo_en_q));

    // Mode and trigger code registers; the clear bit is not stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_en_q  <= 1'b0;
            trig_sel_q <= 2'b00;
        end else if (cfg_wr) begin
            fifo_en_q  <= cfg_fifo_en;
            trig_sel_q <= cfg_trig_sel;
        end
    end

    // Sticky overrun: a discard sets it, a status read clears it, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun_q <= 1'b0;
        end else if (drop) begin
            overrun_q <= 1'b1;
        end else if (lsr_rd) begin
            overrun_q <= 1'b0;
        end
    end

endmodule

// File: rtl/rx_fifo_trig.sv
// Receive buffer with programmable trigger level.
// Stores characters with error flags, reports occupancy, trigger, data
// ready, overrun and an error summary. Assumes one push per cycle at most.
module rx_fifo_trig
    import rxf_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_valid,
    input  logic [7:0]                 push_data,
    input  logic                       push_par,
    input  logic                       push_frm,
    input  logic                       push_brk,
    input  logic                       pop,
    input  logic                       lsr_rd,
    input  logic                       cfg_wr,
    input  logic                       cfg_fifo_en,
    input  logic                       cfg_clr_rx,
    input  logic [1:0]                 cfg_trig_sel,
    output logic [7:0]                 head_data,
    output logic                       head_par,
    output logic                       head_frm,
    output logic                       head_brk,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       data_ready,
    output logic                       trig_hit,
    output logic                       overrun,
    output logic                       fifo_err
);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic             fifo_en_q;
    logic [1:0]       trig_sel_q;
    logic             flush;
    logic             push_ok;
    logic             pop_ok;
    logic             drop;
    logic             any_bad;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] thresh;
    rx_entry_t        in_entry;
    rx_entry_t        head;

    assign in_entry = '{brk: push_brk, frm: push_frm, par: push_par, data: push_data};

    rxf_cfg u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr       (cfg_wr),
        .cfg_fifo_en  (cfg_fifo_en),
        .cfg_clr_rx   (cfg_clr_rx),
        .cfg_trig_sel (cfg_trig_sel),
        .lsr_rd       (lsr_rd),
        .drop         (drop),
        .fifo_en_q    (fifo_en_q),
        .trig_sel_q   (trig_sel_q),
        .flush        (flush),
        .overrun_q    (overrun)
    );

    rxf_occ #(.DEPTH(DEPTH)) u_occ (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .fifo_en  (fifo_en_q),
        .push_req (push_valid),
        .push_bad (push_par | push_frm | push_brk),
        .pop_req  (pop),
        .head_bad (head.par | head.frm | head.brk),
        .push_ok  (push_ok),
        .pop_ok   (pop_ok),
        .drop     (drop),
        .count    (count),
        .any_bad  (any_bad)
    );

    rxf_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .wr_en    (push_ok),
        .rd_en    (pop_ok),
        .wr_entry (in_entry),
        .head     (head)
    );

    // Output decode from stored state.
    always_comb begin
        thresh     = CNT_W'(trig_level(trig_sel_q, DEPTH));
        level      = count;
        data_ready = (count != '0);
        trig_hit   = (count >= thresh);
        fifo_err   = fifo_en_q && any_bad;
        head_data  = head.data;
        head_par   = head.par;
        head_frm   = head.frm;
        head_brk   = head.brk;
    end

endmodule

// File: rtl/rx_fifo_trig_chk.sv
// Temporal checks for rx_fifo_trig, attached with bind.
module rx_fifo_trig_chk #(
    parameter int unsigned DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       push_valid,
    input logic                       lsr_rd,
    input logic                       cfg_wr,
    input logic                       cfg_clr_rx,
    input logic                       fifo_en_q,
    input logic [$clog2(DEPTH+1)-1:0] level,
    input logic                       overrun,
    input logic                       fifo_err
);
    // R10
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= ($clog2(DEPTH+1))'(DEPTH));

    // R5
    hold_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en_q |-> level <= 1);

    // R7
    clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_clr_rx) |=> level == 0);

    // R6
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !lsr_rd) |=> overrun);

    // R6
    ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && !push_valid) |=> !overrun);

    // R9
    err_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en_q |-> !fifo_err);

    // R4
    empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level == 0 && !push_valid && !cfg_wr) |=> level == 0);

endmodule

bind rx_fifo_trig rx_fifo_trig_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (push_valid),
    .lsr_rd     (lsr_rd),
    .cfg_wr     (cfg_wr),
    .cfg_clr_rx (cfg_clr_rx),
    .fifo_en_q  (fifo_en_q),
    .level      (level),
    .overrun    (overrun),
    .fifo_err   (fifo_err)
);

// File: tb/rx_fifo_trig_test.sv
`timescale 1ns/1ps
// Bench for rx_fifo_trig: directed corners then seeded random traffic,
// compared each cycle against a behavioural model built from the brief.
module rx_fifo_trig_test;
    localparam int unsigned DEPTH = 16;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             push_valid = 1'b0;
    logic [7:0]       push_data = '0;
    logic             push_par = 1'b0, push_frm = 1'b0, push_brk = 1'b0;
    logic             pop = 1'b0, lsr_rd = 1'b0;
    logic             cfg_wr = 1'b0, cfg_fifo_en = 1'b0, cfg_clr_rx = 1'b0;
    logic [1:0]       cfg_trig_sel = '0;
    logic [7:0]       head_data;
    logic             head_par, head_frm, head_brk;
    logic [CNT_W-1:0] level;
    logic             data_ready, trig_hit, overrun, fifo_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Model state.
    logic [10:0] mq[$];
    bit          m_en = 0;
    logic [1:0]  m_sel = 0;
    bit          m_ovr = 0;

    always #2.5 clk = ~clk;

    rx_fifo_trig #(.DEPTH(DEPTH)) uut (.*);

    function automatic int lvl_of(input logic [1:0] s);
        case (s)
            2'b00: return 1;
            2'b01: return 4;
            2'b10: return 8;
            default: return 14;
        endcase
    endfunction

    function automatic bit model_err();
        for (int i = 0; i < mq.size(); i++)
            if (mq[i][10:8] != 3'b000) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Compare every output with the model.
    task automatic compare_all();
        check(level == CNT_W'(mq.size()), "R10", "level", level, mq.size());
        check(data_ready == (mq.size() != 0), "R4", "data_ready", data_ready, mq.size() != 0);
        check(trig_hit == (mq.size() >= lvl_of(m_sel)), "R3", "trig_hit",
              trig_hit, mq.size() >= lvl_of(m_sel));
        check(overrun == m_ovr, "R6", "overrun", overrun, m_ovr);
        check(fifo_err == (m_en && model_err()), "R9", "fifo_err", fifo_err,
              m_en && model_err());
        if (mq.size() != 0)
            check({head_brk, head_frm, head_par, head_data} == mq[0], "R2", "head",
                  {head_brk, head_frm, head_par, head_data}, mq[0]);
    endtask

    // Drive one cycle of inputs, advance the model, sample after the edge.
    task automatic step(input bit p, input logic [7:0] d, input logic [2:0] e,
                        input bit pp, input bit lr, input bit w, input bit clr,
                        input bit en, input logic [1:0] sel);
        bit flush, popeff, accept, drop;
        int cap;
        push_valid = p; push_data = d; {push_brk, push_frm, push_par} = e;
        pop = pp; lsr_rd = lr; cfg_wr = w; cfg_clr_rx = clr;
        cfg_fifo_en = en; cfg_trig_sel = sel;
        @(posedge clk);
        flush = w && (clr || (en != m_en));
        cap = m_en ? DEPTH : 1;
        drop = 0;
        if (flush) begin
            mq.delete();
        end else begin
            popeff = pp && (mq.size() != 0);
            accept = p && ((mq.size() < cap) || popeff);
            drop = p && !accept;
            if (popeff) void'(mq.pop_front());
            if (accept) mq.push_back({e, d});
        end
        if (w) begin m_en = en; m_sel = sel; end
        if (drop) m_ovr = 1;
        else if (lr) m_ovr = 0;
        #1;
        compare_all();
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, m_en, m_sel);
    endtask

    task automatic cfg(input bit en, input bit clr, input logic [1:0] sel);
        step(0, 0, 0, 0, 0, 1, clr, en, sel);
    endtask

    initial begin
        void'($urandom(32'h1357_2468));
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check(level == 0 && !data_ready && !trig_hit && !overrun && !fifo_err,
              "R1", "reset outputs", {level, data_ready, trig_hit, overrun, fifo_err}, 0);
        rst_n = 1'b1;
        idle();
        // R4: pop on empty has no effect
        step(0, 0, 0, 1, 0, 0, 0, 0, 0);
        check(level == 0, "R4", "pop on empty", level, 0);

        // R5: holding mode keeps one entry and drops the second
        step(1, 8'hA5, 3'b000, 0, 0, 0, 0, 0, 0);
        step(1, 8'h3C, 3'b001, 0, 0, 0, 0, 0, 0);
        check(level == 1 && head_data == 8'hA5, "R5", "holding keeps first", head_data, 8'hA5);
        check(overrun == 1'b1, "R6", "overrun after hold drop", overrun, 1);
        check(fifo_err == 1'b0, "R9", "no summary in holding mode", fifo_err, 0);
        step(0, 0, 0, 0, 1, 0, 0, 0, 0);
        check(overrun == 1'b0, "R6", "status read clears", overrun, 0);

        // R8: switching to buffered mode flushes
        cfg(1, 0, 2'b11);
        check(level == 0, "R8", "mode toggle flush", level, 0);
        for (int i = 0; i < DEPTH; i++)
            step(1, 8'(i + 16), (i == 3) ? 3'b010 : 3'b000, 0, 0, 0, 0, 1, 2'b11);
        check(level == DEPTH && trig_hit, "R3", "full with level 14", level, DEPTH);
        check(fifo_err == 1'b1, "R9", "frame error stored", fifo_err, 1);
        // R6: push at full with pop is accepted; without pop it overruns
        step(1, 8'hEE, 3'b000, 1, 0, 0, 0, 1, 2'b11);
        check(level == DEPTH && !overrun, "R6", "push+pop at full", level, DEPTH);
        // R6: drop and status read together leave overrun set
        step(1, 8'hEF, 3'b000, 0, 1, 0, 0, 1, 2'b11);
        check(overrun == 1'b1, "R6", "set wins over clear", overrun, 1);
        // R8: same-mode write without clear keeps contents
        cfg(1, 0, 2'b10);
        check(level == DEPTH, "R8", "same-mode write keeps", level, DEPTH);
        // Drain and watch the summary flag drop once the bad entry leaves.
        for (int i = 0; i < DEPTH; i++)
            step(0, 0, 0, 1, 0, 0, 0, 1, 2'b10);
        check(level == 0 && !fifo_err, "R9", "drained summary", fifo_err, 0);

        // R7: clear empties and discards a same-cycle push
        for (int i = 0; i < 5; i++)
            step(1, 8'(i), 3'b100, 0, 1, 0, 0, 1, 2'b01);
        step(1, 8'h77, 3'b000, 0, 0, 1, 1, 1, 2'b01);
        check(level == 0 && !overrun, "R7", "clear flush", level, 0);
        // R8: leaving buffered mode flushes
        for (int i = 0; i < 3; i++)
            step(1, 8'(i), 3'b000, 0, 0, 0, 0, 1, 2'b01);
        cfg(0, 0, 2'b00);
        check(level == 0, "R8", "exit buffered mode flush", level, 0);

        // Seeded random traffic.
        for (int n = 0; n < 4000; n++) begin
            bit w, clr, en;
            logic [1:0] sel;
            w = ($urandom_range(99) < 2);
            clr = w && ($urandom_range(2) == 0);
            en = w ? ($urandom_range(4) != 0) : m_en;
            sel = w ? 2'($urandom_range(3)) : m_sel;
            step($urandom_range(99) < 55, 8'($urandom), 3'($urandom_range(7)) & {3{$urandom_range(3) == 0}},
                 $urandom_range(99) < 40, $urandom_range(99) < 10, w, clr, en, sel);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #500000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule